// File: doc/BRIEF.md
# Interrupt Snapshot Register Unit

This unit gathers the pending flags of eight interrupt sources, four channels with a receive and a transmit source each, and drives one active-low interrupt request line. A host services that line by reading a snapshot register. The snapshot holds the identity of the most urgent pending source, its priority rank and a valid flag.

The snapshot is taken only at two moments. One is an interrupt acknowledge cycle. The other is a write by software to a dedicated command address. It is never taken when the request line goes low. A source of higher priority that arrives between the request and the start of the service routine therefore still shows up in the snapshot. On an acknowledge cycle the unit also places an interrupt vector on its vector bus. That vector is either the plain base vector or the base vector with its low bits replaced by the captured source index. A packed status word mirrors the snapshot for the global status reads.

Top module: `irq_snapshot_unit`

## Requirements
- R1: `irqN` is registered. One cycle after any source that is both pending and enabled is seen at a clock edge, `irqN` is 0. Otherwise it is 1, and it is 1 during reset.
- R2: At a clock edge where `ackStrobe` is 1, the snapshot loads the lowest-indexed source that is both pending and enabled. Index 0 is the most urgent.
- R3: At a clock edge where `cmdWrite` is 1 and `cmdAddr` equals 0x2A, the snapshot loads in the same way as in R2. A write to any other address leaves the snapshot unchanged.
- R4: At any other edge the snapshot holds its value. This includes edges where pending flags change and edges where `irqN` falls.
- R5: A loaded source sets `curValid` to 1 and sets `curPriority` to 7 minus the source index, so that a larger value means more urgent.
- R6: If no enabled source is pending at load time, the snapshot takes the none code: `curValid` 0, `curSource` 0 and `curPriority` 0.
- R7: In the cycle after an acknowledge edge, `vecDrive` is 1 for exactly one cycle. In that cycle `vecOut` equals `vecBase`. When `vecModify` is 1 and the captured source is valid, `vecOut` is instead `vecBase[7:3]` followed by the 3-bit source index. When `vecDrive` is 0, `vecOut` is 0.
- R8: `statusWord` is {curValid, curPriority[2:0], 1'b0, curSource[2:0]}, with bit 7 being the valid bit.
- R9: After reset, `irqN` is 1, the snapshot holds the none code, `vecDrive` is 0 and `vecOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcPending | input | 8 | Pending flag of each source |
| srcEnable | input | 8 | Enable mask of each source |
| ackStrobe | input | 1 | Interrupt acknowledge cycle, one clock per cycle |
| cmdWrite | input | 1 | Command write strobe |
| cmdAddr | input | 8 | Command write address |
| vecBase | input | 8 | Base interrupt vector |
| vecModify | input | 1 | Puts the source index into the vector when 1 |
| irqN | output | 1 | Interrupt request, active low |
| curValid | output | 1 | Snapshot holds a source |
| curSource | output | 3 | Captured source index |
| curPriority | output | 3 | Captured priority rank |
| vecDrive | output | 1 | Vector bus carries a vector |
| vecOut | output | 8 | Vector bus |
| statusWord | output | 8 | Status mirror of the snapshot |

## Verification
The assertions take for granted that `ackStrobe` and the command strobe are synchronous to `clk`. They also expect each acknowledge to be one clock long, so that the one-cycle vector window can be related to a single prior strobe. The bench changes every input only at the falling clock edge. It gives each acknowledge for exactly one clock and returns the strobes to 0 between table rows unless a row asks for them again. The pending flags are treated as arbitrary levels, and the stimulus changes them freely between snapshots.

// File: rtl/irq_snap_pkg.sv
package irq_snap_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic loadCir;   // take a snapshot at this edge
    logic driveVec;  // present a vector in the next cycle
  } snapStrobeT;

endpackage

// File: rtl/irq_snap_ctrl.sv
module irq_snap_ctrl
  import irq_snap_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CMD_ADDR = 8'h2A
) (
  input  logic              ackStrobe,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  output snapStrobeT        strobes
);

  localparam logic [ADDR_W-1:0] SnapAddr = ADDR_W'(CMD_ADDR);

  logic cmdHit;

  always_comb begin
    cmdHit           = cmdWrite && (cmdAddr == SnapAddr);
    strobes.loadCir  = ackStrobe || cmdHit;
    strobes.driveVec = ackStrobe;
  end

endmodule

// File: rtl/irq_snap_datapath.sv
module irq_snap_datapath
  import irq_snap_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int STAT_W = 2 * SRC_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPending,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [VEC_W-1:0]   vecBase,
  input  logic               vecModify,
  input  snapStrobeT         strobes,
  output logic               irqN,
  output logic               curValid,
  output logic [SRC_W-1:0]   curSource,
  output logic [SRC_W-1:0]   curPriority,
  output logic               vecDrive,
  output logic [VEC_W-1:0]   vecOut,
  output logic [STAT_W-1:0]  statusWord
);

  localparam logic [SRC_W-1:0] TopRank = SRC_W'(NUM_SRC - 1);

  logic [NUM_SRC-1:0] liveReq;
  logic [NUM_SRC-1:0] winOneHot;
  logic [NUM_SRC-1:0] lowerSeen;
  logic               anyLive;
  logic [SRC_W-1:0]   winIdx;
  logic [VEC_W-1:0]   nextVec;

  // Fixed priority: a source wins when no lower index is live
  assign liveReq      = srcPending & srcEnable;
  assign lowerSeen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gSrc
      assign winOneHot[g] = liveReq[g] && !lowerSeen[g];
      if (g < NUM_SRC - 1) begin : gChain
        assign lowerSeen[g+1] = lowerSeen[g] || liveReq[g];
      end
    end
  endgenerate

  always_comb begin
    anyLive = |liveReq;
    winIdx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (winOneHot[i]) winIdx = SRC_W'(i);
    end
    if (vecModify && anyLive) nextVec = {vecBase[VEC_W-1:SRC_W], winIdx};
    else                      nextVec = vecBase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqN        <= 1'b1;
      curValid    <= 1'b0;
      curSource   <= '0;
      curPriority <= '0;
      vecDrive    <= 1'b0;
      vecOut      <= '0;
    end else begin
      irqN     <= !anyLive;
      vecDrive <= strobes.driveVec;
      vecOut   <= strobes.driveVec ? nextVec : '0;
      if (strobes.loadCir) begin
        curValid    <= anyLive;
        curSource   <= anyLive ? winIdx : '0;
        curPriority <= anyLive ? (TopRank - winIdx) : '0;
      end
    end
  end

  assign statusWord = {curValid, curPriority, 1'b0, curSource};

  // R1: a live source drives the request low in the next cycle
  a_r1_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    anyLive |=> !irqN);

  // R4: without a load strobe the snapshot does not move
  a_r4_snapshot_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadCir |=> ($stable(curSource) && $stable(curValid)
                          && $stable(curPriority)));

  // R6: an invalid snapshot carries the none code
  a_r6_none_code: assert property (@(posedge clk) disable iff (!rstN)
    !curValid |-> (curSource == '0 && curPriority == '0));

  // R7: the vector appears only right after a drive strobe
  a_r7_vec_window: assert property (@(posedge clk) disable iff (!rstN)
    vecDrive |-> $past(strobes.driveVec));

  // R7: the bus is released outside the vector window
  a_r7_bus_idle: assert property (@(posedge clk) disable iff (!rstN)
    !vecDrive |-> vecOut == '0);

  // R2: a load while a source is live produces a valid snapshot
  a_r2_load_valid: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadCir && anyLive) |=> curValid);

endmodule

// File: rtl/irq_snapshot_unit.sv
module irq_snapshot_unit
  import irq_snap_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int CMD_ADDR = 8'h2A,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int STAT_W  = 2 * SRC_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPending,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               ackStrobe,
  input  logic               cmdWrite,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [VEC_W-1:0]   vecBase,
  input  logic               vecModify,
  output logic               irqN,
  output logic               curValid,
  output logic [SRC_W-1:0]   curSource,
  output logic [SRC_W-1:0]   curPriority,
  output logic               vecDrive,
  output logic [VEC_W-1:0]   vecOut,
  output logic [STAT_W-1:0]  statusWord
);

  snapStrobeT strobes;

  irq_snap_ctrl #(
    .ADDR_W   (ADDR_W),
    .CMD_ADDR (CMD_ADDR)
  ) u_ctrl (
    .ackStrobe (ackStrobe),
    .cmdWrite  (cmdWrite),
    .cmdAddr   (cmdAddr),
    .strobes   (strobes)
  );

  irq_snap_datapath #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .srcPending  (srcPending),
    .srcEnable   (srcEnable),
    .vecBase     (vecBase),
    .vecModify   (vecModify),
    .strobes     (strobes),
    .irqN        (irqN),
    .curValid    (curValid),
    .curSource   (curSource),
    .curPriority (curPriority),
    .vecDrive    (vecDrive),
    .vecOut      (vecOut),
    .statusWord  (statusWord)
  );

endmodule

// File: tb/irq_snapshot_unit_bench.sv
module irq_snapshot_unit_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] srcPending = '0;
  logic [7:0] srcEnable = '0;
  logic       ackStrobe = 1'b0;
  logic       cmdWrite = 1'b0;
  logic [7:0] cmdAddr = '0;
  logic [7:0] vecBase = 8'hA0;
  logic       vecModify = 1'b0;
  logic       irqN;
  logic       curValid;
  logic [2:0] curSource;
  logic [2:0] curPriority;
  logic       vecDrive;
  logic [7:0] vecOut;
  logic [7:0] statusWord;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_snapshot_unit u_irq_snapshot_unit (
    .clk (clk), .rstN (rstN), .srcPending (srcPending), .srcEnable (srcEnable),
    .ackStrobe (ackStrobe), .cmdWrite (cmdWrite), .cmdAddr (cmdAddr),
    .vecBase (vecBase), .vecModify (vecModify), .irqN (irqN),
    .curValid (curValid), .curSource (curSource), .curPriority (curPriority),
    .vecDrive (vecDrive), .vecOut (vecOut), .statusWord (statusWord)
  );

  // Row: pend, en, ack, wr, addr, mod | expValid, expSrc, expVd, expVec
  localparam int ROWS = 11;
  localparam logic [39:0] Table [ROWS] = '{
    {8'h00, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 8'hA0}, // R6 none on ack
    {8'h30, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 3'd4, 1'b1, 8'hA4}, // R2 R7 modified
    {8'h30, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'd4, 1'b0, 8'h00}, // R7 one shot
    {8'h31, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'd4, 1'b0, 8'h00}, // R4 late urgent
    {8'h31, 8'hFF, 1'b0, 1'b1, 8'h2A, 1'b1, 1'b1, 3'd0, 1'b0, 8'h00}, // R3 command
    {8'h30, 8'hFF, 1'b0, 1'b1, 8'h2B, 1'b1, 1'b1, 3'd0, 1'b0, 8'h00}, // R3 wrong addr
    {8'h30, 8'hEF, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 3'd5, 1'b1, 8'hA5}, // R2 masked
    {8'h80, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 3'd7, 1'b1, 8'hA0}, // R7 plain
    {8'h80, 8'h7F, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 8'hA0}, // R6 masked none
    {8'h04, 8'hFF, 1'b1, 1'b1, 8'h2A, 1'b1, 1'b1, 3'd2, 1'b1, 8'hA2}, // R2 both strobes
    {8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 3'd2, 1'b0, 8'h00}  // R1 R4 idle
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkReset();
    check("R9", "irqN",       {7'd0, irqN},     8'h01);
    check("R9", "curValid",   {7'd0, curValid}, 8'h00);
    check("R9", "statusWord", statusWord,       8'h00);
    check("R9", "vecDrive",   {7'd0, vecDrive}, 8'h00);
    check("R9", "vecOut",     vecOut,           8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    @(negedge clk);

    for (int r = 0; r < ROWS; r++) begin
      logic [39:0] row;
      logic [2:0]  eSrc;
      logic [2:0]  ePrio;
      logic        eValid;
      logic        eIrqN;
      row        = Table[r];
      srcPending = row[39:32];
      srcEnable  = row[31:24];
      ackStrobe  = row[23];
      cmdWrite   = row[22];
      cmdAddr    = row[21:14];
      vecModify  = row[13];
      eValid     = row[12];
      eSrc       = row[11:9];
      ePrio      = eValid ? 3'd7 - eSrc : 3'd0;           // R5
      eIrqN      = ~|(row[39:32] & row[31:24]);            // R1
      @(posedge clk);
      @(negedge clk);
      check("R1", "irqN",        {7'd0, irqN},        {7'd0, eIrqN});
      check("R2", "curValid",    {7'd0, curValid},    {7'd0, eValid});
      check("R4", "curSource",   {5'd0, curSource},   {5'd0, eSrc});
      check("R5", "curPriority", {5'd0, curPriority}, {5'd0, ePrio});
      check("R7", "vecDrive",    {7'd0, vecDrive},    {7'd0, row[8]});
      check("R7", "vecOut",      vecOut,              row[7:0]);
      check("R8", "statusWord",  statusWord,          {eValid, ePrio, 1'b0, eSrc});
      ackStrobe = 1'b0;
      cmdWrite  = 1'b0;
    end

    // R4: irq falls while the snapshot stays, source 1 arrives late
    srcPending = 8'h02; srcEnable = 8'hFF;
    @(posedge clk); @(negedge clk);
    check("R4", "irqN",      {7'd0, irqN},      8'h00);
    check("R4", "curSource", {5'd0, curSource}, 8'h02);

    // R9: reset with live sources keeps the request high
    rstN = 1'b0;
    srcPending = 8'hFF; srcEnable = 8'hFF;
    repeat (2) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", "irqN after reset", {7'd0, irqN}, 8'h00);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule